// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block drives a serial EEPROM that stores 16-bit words and is reached over a chip select, a serial clock, one data line toward the memory and one data line back. A single start pulse launches one complete transaction. The transaction is one of four operations: enabling writes, writing a word, reading a word, or erasing a word. The caller supplies the operation, the word address, the address width (6 or 8 bits) and the write data. The block builds the serial frame, clocks it out, collects any returned word and, after a write or an erase, waits for the memory to report that programming has finished.

The serial clock comes from the system clock through a run-time divisor. Each half of a serial clock period lasts one divided tick. A detection mode runs a read of word 0 with the short address. If the returned word is all ones, the block records that the part needs the long address. Software then uses that result in the width input for later transactions.

Top module: `sprom_seq`

## Requirements
- R1: Every frame is sent MSB first as a 1 start bit, a 2-bit opcode (enable 00, write 01, read 10, erase 11) and the address. The enable operation sends an all-ones address. Enable and erase frames carry 3+AW clocks. Read and write frames carry 3+AW+16 clocks.
- R2: `wide`=0 selects a 6-bit address field, using `addr[5:0]`. `wide`=1 selects an 8-bit field.
- R3: `mem_tx` changes only while `mem_sck` is low. It holds its value for the whole high phase.
- R4: A read returns 16 bits MSB first, each sampled while `mem_sck` is high. `rdata` holds the word from the cycle in which `done` pulses.
- R5: A write frame carries the 16 data bits MSB first, directly after the address.
- R6: `mem_cs` is low before and after every frame, and `mem_sck` pulses only while `mem_cs` is high. After a write or erase frame, `mem_cs` stays low for at least GAP_TICKS ticks before it rises again for polling.
- R7: After the gap, a write or erase holds `mem_cs` high and samples `mem_rx` on each tick. When `mem_rx` reads 1, it drops `mem_cs` and pulses `done`.
- R8: If `mem_rx` has not read 1 within POLL_LIMIT system cycles of polling, `timeout` pulses instead of `done` and `mem_cs` is dropped.
- R9: Each high phase of `mem_sck` lasts exactly `div`+1 system cycles, and no phase is shorter.
- R10: A start is accepted only while `busy` is low, and `busy` rises in the next cycle. A start that arrives while busy has no effect on the frame in progress and launches nothing.
- R11: `done` and `timeout` are single-cycle pulses. They are never high together, and `busy` is low when either is high.
- R12: With `detect` high, the block reads word 0 with a 6-bit address, ignoring `op`, `addr` and `wide`. It sets `wide_found` if and only if the word is all ones. Other operations leave `wide_found` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one transaction (taken only when idle) |
| op | input | 2 | Operation code: 00 enable, 01 write, 10 read, 11 erase |
| addr | input | AW_WIDE | Word address |
| wide | input | 1 | 0: 6-bit address, 1: 8-bit address |
| wdata | input | DATA_W | Word to write |
| detect | input | 1 | With start, run the width detection read instead |
| div | input | DIV_W | Divisor: one tick every div+1 cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when programming never completes |
| rdata | output | DATA_W | Last word read |
| wide_found | output | 1 | Result of the last detection read |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_sck | output | 1 | Memory serial clock |
| mem_tx | output | 1 | Serial data toward the memory |
| mem_rx | input | 1 | Serial data and ready status from the memory |

## Verification
The bench sweeps all four operations over both address widths and two divisors, at the lowest, a middle and the highest address. It writes each address with a pattern derived from the address and the configuration, then reads it back. This separates errors in opcode placement, address truncation, bit order and the sampling phase. Against a memory that never signals ready, the bench checks that `timeout` fires in place of `done` and at the right cycle. A start pulse given in the middle of a transaction must produce no extra frame. Detection runs on a word 0 of all ones, of all ones but one bit, and of an ordinary value, which pins down the all-ones decision.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   typedef enum logic [1:0] {
      OPC_WREN  = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_ERASE = 2'b11
   } sprom_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL,
      ST_GAP,
      ST_POLL,
      ST_CLOSE
   } sprom_st_e;

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || cnt == div) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && (cnt == div);

endmodule

// File: rtl/sprom_watch.sv
module sprom_watch #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != W'(LIMIT)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && (cnt == W'(LIMIT));

endmodule

// File: rtl/sprom_frame.sv
module sprom_frame
   import sprom_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int AW_N   = 6,
   parameter int AW_W   = 8,
   parameter int CNT_W  = 5
) (
   input  sprom_op_e                op,
   input  logic [AW_W-1:0]          addr,
   input  logic                     wide,
   input  logic [DATA_W-1:0]        wdata,
   output logic [3+AW_W+DATA_W-1:0] frame,
   output logic [CNT_W-1:0]         nbits
);

   logic [AW_W-1:0]   a_eff;
   logic [DATA_W-1:0] d_eff;

   always_comb begin
      a_eff = (op == OPC_WREN) ? '1 : addr;
      d_eff = (op == OPC_WRITE) ? wdata : '0;
   end

   generate
      if (AW_W > AW_N) begin : g_pad
         localparam int PAD = AW_W - AW_N;
         assign frame = wide ? {1'b1, op, a_eff, d_eff}
                             : {1'b1, op, a_eff[AW_N-1:0], d_eff, {PAD{1'b0}}};
      end else begin : g_same
         assign frame = {1'b1, op, a_eff, d_eff};
      end
   endgenerate

   always_comb begin
      nbits = CNT_W'(3) + (wide ? CNT_W'(AW_W) : CNT_W'(AW_N));
      if (op == OPC_WRITE || op == OPC_READ) begin
         nbits = nbits + CNT_W'(DATA_W);
      end
   end

endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
   import sprom_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int AW_NARROW  = 6,
   parameter int AW_WIDE    = 8,
   parameter int DIV_W      = 8,
   parameter int GAP_TICKS  = 2,
   parameter int POLL_LIMIT = 12_500_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         op,
   input  logic [AW_WIDE-1:0] addr,
   input  logic               wide,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               detect,
   input  logic [DIV_W-1:0]   div,
   output logic               busy,
   output logic               done,
   output logic               timeout,
   output logic [DATA_W-1:0]  rdata,
   output logic               wide_found,
   output logic               mem_cs,
   output logic               mem_sck,
   output logic               mem_tx,
   input  logic               mem_rx
);

   localparam int SR_W  = 3 + AW_WIDE + DATA_W;
   localparam int CNT_W = $clog2(SR_W + 1);
   localparam int GW    = $clog2(GAP_TICKS + 1);

   generate
      if (AW_NARROW < 1 || AW_WIDE < AW_NARROW) begin : g_bad_aw
         $error("sprom_seq: address widths must satisfy 1 <= AW_NARROW <= AW_WIDE");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("sprom_seq: DATA_W must be at least 2");
      end
      if (GAP_TICKS < 1 || POLL_LIMIT < 1 || DIV_W < 1) begin : g_bad_tm
         $error("sprom_seq: GAP_TICKS, POLL_LIMIT and DIV_W must be positive");
      end
   endgenerate

   sprom_st_e         state;
   logic              ph;
   logic [SR_W-1:0]   sreg;
   logic [CNT_W-1:0]  left;
   logic [DATA_W-1:0] rx;
   sprom_op_e         cur_op;
   logic              cur_det;
   logic [GW-1:0]     gapc;
   logic              tflag;

   logic              tick;
   logic              expired;
   logic              polls;

   sprom_op_e         b_op;
   logic [AW_WIDE-1:0] b_addr;
   logic              b_wide;
   logic [SR_W-1:0]   b_frame;
   logic [CNT_W-1:0]  b_nbits;

   always_comb begin
      b_op   = detect ? OPC_READ : sprom_op_e'(op);
      b_addr = detect ? '0 : addr;
      b_wide = detect ? 1'b0 : wide;
   end

   sprom_frame #(
      .DATA_W (DATA_W),
      .AW_N   (AW_NARROW),
      .AW_W   (AW_WIDE),
      .CNT_W  (CNT_W)
   ) u_frame (
      .op     (b_op),
      .addr   (b_addr),
      .wide   (b_wide),
      .wdata  (wdata),
      .frame  (b_frame),
      .nbits  (b_nbits)
   );

   sprom_tick #(
      .DIV_W (DIV_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div   (div),
      .tick  (tick)
   );

   sprom_watch #(
      .LIMIT (POLL_LIMIT)
   ) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_POLL),
      .expired (expired)
   );

   assign polls = (cur_op == OPC_WRITE) || (cur_op == OPC_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ph         <= 1'b0;
         sreg       <= '0;
         left       <= '0;
         rx         <= '0;
         cur_op     <= OPC_WREN;
         cur_det    <= 1'b0;
         gapc       <= '0;
         tflag      <= 1'b0;
         done       <= 1'b0;
         timeout    <= 1'b0;
         rdata      <= '0;
         wide_found <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  sreg    <= b_frame;
                  left    <= b_nbits;
                  cur_op  <= b_op;
                  cur_det <= detect;
                  rx      <= '0;
                  tflag   <= 1'b0;
                  ph      <= 1'b0;
                  state   <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  state <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!ph) begin
                     ph <= 1'b1;
                  end else begin
                     ph <= 1'b0;
                     if (cur_op == OPC_READ && left <= CNT_W'(DATA_W)) begin
                        rx <= {rx[DATA_W-2:0], mem_rx};
                     end
                     sreg <= {sreg[SR_W-2:0], 1'b0};
                     left <= left - 1'b1;
                     if (left == CNT_W'(1)) begin
                        state <= ST_TRAIL;
                     end
                  end
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  gapc  <= '0;
                  state <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gapc == GW'(GAP_TICKS - 1)) begin
                     if (polls) begin
                        state <= ST_POLL;
                     end else begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                        if (cur_op == OPC_READ) begin
                           rdata <= rx;
                        end
                        if (cur_det) begin
                           wide_found <= &rx;
                        end
                     end
                  end else begin
                     gapc <= gapc + 1'b1;
                  end
               end
            end
            ST_POLL: begin
               if (tick && mem_rx) begin
                  state <= ST_CLOSE;
               end else if (expired) begin
                  tflag <= 1'b1;
                  state <= ST_CLOSE;
               end
            end
            ST_CLOSE: begin
               if (tick) begin
                  done    <= !tflag;
                  timeout <= tflag;
                  state   <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign mem_cs  = (state == ST_SHIFT) || (state == ST_TRAIL) || (state == ST_POLL);
   assign mem_sck = (state == ST_SHIFT) && ph;
   assign mem_tx  = (state == ST_SHIFT) && sreg[SR_W-1];

endmodule

// File: rtl/sprom_seq_chk.sv
module sprom_seq_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             timeout,
   input logic             mem_cs,
   input logic             mem_sck,
   input logic             mem_tx,
   input logic [DIV_W-1:0] div
);

   logic [15:0] run_len;
   logic        sk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '1;
         sk_q    <= 1'b0;
      end else begin
         sk_q <= mem_sck;
         if (mem_sck != sk_q) begin
            run_len <= 16'd1;
         end else if (run_len != '1) begin
            run_len <= run_len + 16'd1;
         end
      end
   end

   assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sck && sk_q) |-> $stable(mem_tx));

   assert_sck_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sck |-> mem_cs);

   assert_half_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (mem_sck != sk_q)) |-> (int'(run_len) >= int'(div) + 1));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_cs && !mem_sck));

   assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_timeout_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> !busy);

endmodule

bind sprom_seq sprom_seq_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .timeout (timeout),
   .mem_cs  (mem_cs),
   .mem_sck (mem_sck),
   .mem_tx  (mem_tx),
   .div     (div)
);

// File: tb/test_sprom_seq.sv
module test_sprom_seq;

   localparam int DW   = 16;
   localparam int AWN  = 6;
   localparam int AWW  = 8;
   localparam int DIVW = 4;
   localparam int GAP  = 2;
   localparam int PLIM = 400;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n;
   logic           start;
   logic [1:0]     op_i;
   logic [AWW-1:0] addr_i;
   logic           wide_i;
   logic [DW-1:0]  wdata_i;
   logic           detect_i;
   logic [DIVW-1:0] div_i;
   logic           busy, done, timeout, wide_found;
   logic [DW-1:0]  rdata;
   logic           mem_cs, mem_sck, mem_tx, mem_rx;

   sprom_seq #(
      .DATA_W(DW), .AW_NARROW(AWN), .AW_WIDE(AWW), .DIV_W(DIVW),
      .GAP_TICKS(GAP), .POLL_LIMIT(PLIM)
   ) i_sprom_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .addr(addr_i),
      .wide(wide_i), .wdata(wdata_i), .detect(detect_i), .div(div_i),
      .busy(busy), .done(done), .timeout(timeout), .rdata(rdata),
      .wide_found(wide_found), .mem_cs(mem_cs), .mem_sck(mem_sck),
      .mem_tx(mem_tx), .mem_rx(mem_rx)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit fin     = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mem [256];
   int   m_aw = 6;
   int   m_busy_cyc = 60;
   bit   m_stuck = 1'b0;
   int   pre_req = 0, pre_done = 0;
   logic [7:0]  pre_adr;
   logic [15:0] pre_val;
   int   clr_req = 0, clr_done = 0;

   bit   m_wen = 1'b0;
   int   m_cnt = 0;
   logic [31:0] m_sh = '0;
   logic [1:0]  m_op = '0;
   logic [7:0]  m_adr = '0;
   bit   m_start_ok = 1'b0;
   bit   m_rd_drive = 1'b0;
   logic m_rd_bit = 1'b0;
   int   m_busy_left = 0;
   int   m_frames = 0, m_last_cnt = 0;
   logic [1:0] m_last_op = '0;
   logic [7:0] m_last_adr = '0;
   bit   m_last_start = 1'b0;
   bit   m_skq = 1'b0, m_csq = 1'b0;
   logic m_txq = 1'b0;
   int   m_di_bad = 0;
   int   m_hi_run = 0, m_min_hi = 1000, m_max_hi = 0;
   int   m_lowrun = 0, m_last_gap = 0;

   assign mem_rx = m_rd_drive ? m_rd_bit : (!m_stuck && m_busy_left == 0);

   always @(negedge clk) begin
      if (pre_req != pre_done) begin
         mem[pre_adr] = pre_val;
         pre_done = pre_req;
      end
      if (clr_req != clr_done) begin
         m_min_hi = 1000;
         m_max_hi = 0;
         clr_done = clr_req;
      end
      if (m_busy_left > 0) m_busy_left--;
      if (mem_cs && !m_csq) m_last_gap = m_lowrun;
      if (!mem_cs) m_lowrun++; else m_lowrun = 0;
      if (!mem_cs) begin
         if (m_cnt > 0) begin
            m_frames++;
            m_last_cnt   = m_cnt;
            m_last_op    = m_op;
            m_last_adr   = m_adr;
            m_last_start = m_start_ok;
            if (m_op == 2'b00 && m_cnt == 3 + m_aw && m_adr[m_aw-1 -: 2] == 2'b11)
               m_wen = 1'b1;
            if (m_op == 2'b01 && m_cnt == 3 + m_aw + 16 && m_wen) begin
               mem[m_adr] = m_sh[15:0];
               m_busy_left = m_busy_cyc;
            end
            if (m_op == 2'b11 && m_cnt == 3 + m_aw && m_wen) begin
               mem[m_adr] = 16'hFFFF;
               m_busy_left = m_busy_cyc;
            end
         end
         m_cnt = 0;
         m_rd_drive = 1'b0;
      end else if (mem_sck && !m_skq) begin
         m_sh = {m_sh[30:0], mem_tx};
         m_cnt++;
         if (m_cnt == 3 + m_aw) begin
            m_op       = m_sh[m_aw+1 -: 2];
            m_adr      = m_sh[7:0] & 8'((1 << m_aw) - 1);
            m_start_ok = m_sh[m_aw+2];
         end
         if (m_cnt > 3 + m_aw && m_op == 2'b10 && m_cnt <= 3 + m_aw + 16) begin
            m_rd_drive = 1'b1;
            m_rd_bit   = mem[m_adr][19 + m_aw - m_cnt];
         end
      end
      if (mem_sck) begin
         if (m_skq && mem_tx !== m_txq) m_di_bad++;
         m_hi_run++;
      end else if (m_skq) begin
         if (m_hi_run < m_min_hi) m_min_hi = m_hi_run;
         if (m_hi_run > m_max_hi) m_max_hi = m_hi_run;
         m_hi_run = 0;
      end
      m_skq = mem_sck;
      m_txq = mem_tx;
      m_csq = mem_cs;
   end

   // ---------------- stimulus helpers ----------------
   bit got_done, got_to;
   int cyc, ndone;

   task automatic preload(input logic [7:0] a, input logic [15:0] v);
      @(negedge clk);
      pre_adr = a;
      pre_val = v;
      pre_req++;
      @(negedge clk);
   endtask

   task automatic wait_end();
      got_done = 1'b0; got_to = 1'b0; ndone = 0;
      while (!got_done && !got_to && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (done) begin got_done = 1'b1; ndone++; end
         if (timeout) got_to = 1'b1;
      end
      repeat (3) begin
         @(negedge clk);
         if (done) ndone++;
      end
   endtask

   task automatic run_op(input logic [1:0] o, input logic [7:0] a, input bit w,
                         input logic [15:0] d, input bit det);
      @(negedge clk);
      clr_req++;
      op_i = o; addr_i = a; wide_i = w; wdata_i = d; detect_i = det;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      wait_end();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      rst_n = 1'b0; start = 1'b0; op_i = '0; addr_i = '0; wide_i = 1'b0;
      wdata_i = '0; detect_i = 1'b0; div_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_cs && !mem_sck && !done && !timeout, "R10", "reset idle outputs",
            {busy, mem_cs, mem_sck, done, timeout}, 0);
      check(wide_found == 1'b0 && rdata == '0, "R12", "reset width flag and data",
            {wide_found, rdata}, 0);

      for (int dv = 0; dv <= 2; dv += 2) begin
         for (int w = 0; w < 2; w++) begin
            int aw;
            logic [7:0] mask;
            aw   = w ? AWW : AWN;
            mask = 8'((1 << aw) - 1);
            div_i = DIVW'(dv);
            m_aw  = aw;
            @(negedge clk);

            run_op(2'b00, 8'h00, w[0], 16'h0, 1'b0);
            check(got_done, "R1", "enable completes", got_done, 1);
            check(m_last_cnt == 3 + aw && m_last_start, "R1", "enable frame clocks",
                  m_last_cnt, 3 + aw);
            check(m_last_op == 2'b00 && m_last_adr == mask, "R1", "enable opcode and all-ones address",
                  {m_last_op, m_last_adr}, {2'b00, mask});

            for (int k = 0; k < 3; k++) begin
               logic [7:0]  a, a_in;
               logic [15:0] d;
               a    = (k == 0) ? 8'h00 : (k == 1) ? 8'h05 : mask;
               a_in = w ? a : (a | 8'hC0);
               d    = 16'h5A3C ^ (16'(a) * 16'h0111) ^ 16'(dv << 12) ^ 16'(w << 7);

               run_op(2'b01, a_in, w[0], d, 1'b0);
               check(got_done && !got_to, "R7", "write completes after ready", {got_done, got_to}, 2'b10);
               check(ndone == 1, "R11", "single done pulse on write", ndone, 1);
               check(m_last_cnt == 3 + aw + 16 && m_last_op == 2'b01, "R5", "write frame clocks",
                     m_last_cnt, 3 + aw + 16);
               check(m_last_adr == a, "R2", "address field width", m_last_adr, a);
               check(mem[a] == d, "R5", "written word", mem[a], d);
               check(m_last_gap >= GAP * (dv + 1), "R6", "select gap before poll",
                     m_last_gap, GAP * (dv + 1));

               run_op(2'b10, a_in, w[0], 16'hDEAD, 1'b0);
               check(got_done && rdata == d, "R4", "read data", rdata, d);
               check(m_last_cnt == 3 + aw + 16 && m_last_op == 2'b10, "R1", "read frame clocks",
                     m_last_cnt, 3 + aw + 16);
               check(m_min_hi == dv + 1 && m_max_hi == dv + 1, "R9", "clock high phase length",
                     m_min_hi, dv + 1);
            end

            run_op(2'b11, 8'h05, w[0], 16'h0, 1'b0);
            check(got_done && m_last_cnt == 3 + aw && m_last_op == 2'b11, "R1", "erase frame",
                  m_last_cnt, 3 + aw);
            run_op(2'b10, 8'h05, w[0], 16'h0, 1'b0);
            check(rdata == 16'hFFFF, "R1", "erased word reads ones", rdata, 16'hFFFF);
         end
      end

      // timeout against a memory that never becomes ready
      div_i = '0; m_aw = AWN; m_stuck = 1'b1;
      run_op(2'b01, 8'h09, 1'b0, 16'h1357, 1'b0);
      check(got_to && !got_done, "R8", "timeout instead of done", {got_to, got_done}, 2'b10);
      check(cyc >= PLIM && cyc <= PLIM + 120, "R8", "timeout latency", cyc, PLIM);
      check(!mem_cs && !busy, "R6", "select dropped after timeout", {mem_cs, busy}, 0);
      m_stuck = 1'b0;
      repeat (80) @(negedge clk);

      // start while busy has no effect
      begin
         int f0;
         logic [15:0] exp_v;
         exp_v = mem[8'h05];
         f0 = m_frames;
         @(negedge clk);
         op_i = 2'b10; addr_i = 8'h05; wide_i = 1'b0; detect_i = 1'b0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(busy, "R10", "busy after accepted start", busy, 1);
         repeat (10) @(negedge clk);
         op_i = 2'b01; addr_i = 8'h21; wdata_i = 16'h0F0F;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc = 12;
         wait_end();
         repeat (20) @(negedge clk);
         check(m_frames == f0 + 1 && m_last_op == 2'b10, "R10", "start while busy ignored",
               m_frames - f0, 1);
         check(rdata == exp_v && !busy, "R10", "original read result kept", rdata, exp_v);
      end

      // width detection
      preload(8'h00, 16'h1234);
      run_op(2'b01, 8'h07, 1'b1, 16'hAAAA, 1'b1);
      check(m_last_cnt == 3 + AWN + 16 && m_last_op == 2'b10 && m_last_adr == 8'h00, "R12",
            "detect sends short read of word 0", m_last_cnt, 3 + AWN + 16);
      check(wide_found == 1'b0 && rdata == 16'h1234, "R12", "ordinary word keeps short width",
            {wide_found, rdata}, {1'b0, 16'h1234});
      preload(8'h00, 16'hFFFF);
      run_op(2'b00, 8'h33, 1'b0, 16'h0, 1'b1);
      check(wide_found == 1'b1, "R12", "all-ones word selects long width", wide_found, 1);
      preload(8'h00, 16'hFFFE);
      run_op(2'b10, 8'h00, 1'b0, 16'h0, 1'b1);
      check(wide_found == 1'b0, "R12", "one zero bit keeps short width", wide_found, 0);
      preload(8'h00, 16'hFFFF);
      run_op(2'b10, 8'h00, 1'b0, 16'h0, 1'b1);
      preload(8'h00, 16'h0000);
      run_op(2'b10, 8'h00, 1'b0, 16'h0, 1'b0);
      check(wide_found == 1'b1 && rdata == 16'h0000, "R12", "plain read leaves width flag",
            {wide_found, rdata}, {1'b1, 16'h0000});

      check(m_di_bad == 0, "R3", "data stable while clock high", m_di_bad, 0);

      fin = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule